// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Automatic Resend

This block drives the single bidirectional line of a half-duplex smart-card link in the transmit direction. A byte placed in its holding register goes out as a character: one low start bit, eight data bits least significant first, and an even parity bit. Each bit lasts one elementary time unit (etu), and `etu_len` clock cycles make one etu. After the parity bit the block releases the line. Halfway through the next etu it samples the line to see whether the card is pulling it low to report an error.

If the card reports an error, the block latches a sticky error flag. It then sends the same byte again from the holding register, with no software action. The completion and data-empty flags stay low until a character gets through without an error report, and then both rise in the same cycle. When data-empty is set and its enable is on, a transfer request asks a DMA-style controller for the next byte. Whether that controller's write also clears the flags depends on the controller's keep-flags control and its remaining-count value.

Top module: `cardtx_retry`

## Requirements
- R1: In reset and just after it, `line_out` is 1 (released), `flag_empty` is 1, `flag_end` is 1 and `flag_err` is 0.
- R2: When the block is idle, `tx_en` is 1 and `flag_empty` is 0, a character starts at the next clock edge. Each bit holds `line_out` for `etu_len` cycles. Bit 0 is the start bit (0). Bits 1 to 8 are data bits 0 to 7 of the holding register. Bit 9 is the even-parity bit (the XOR of the eight data bits).
- R3: From etu 10 of a character onward, and whenever the block is idle, `line_out` is 1.
- R4: The block samples `line_in` at cycle 10·etu_len + etu_len/2 after the character start. A 0 sets `flag_err` at that edge. A 1 leaves `flag_err` unchanged.
- R5: `irq_err` equals `flag_err` AND `ie_err`.
- R6: After an error report, `flag_end` and `flag_empty` stay 0 and `tx_req` stays 0. The byte currently in the holding register starts again exactly 14 etu after the failed start.
- R7: A character with no error report finishes 12 etu after its start. At that edge `flag_empty` and `flag_end` both become 1.
- R8: `tx_req` equals `flag_empty` AND `ie_tx`.
- R9: A write with `wr_ctrl`=1 stores `wr_data`. It clears `flag_empty` and `flag_end` only when `ctrl_keep`=0 and `ctrl_left` is nonzero. Any other write stores the byte and leaves both flags as they were.
- R10: Only `clr_err` clears `flag_err`. `clr_empty` and `clr_end` clear their own flags. The start of a character clears `flag_end`. A flag set in the same cycle as a clear wins.
- R11: While `tx_en` is 0, no character starts, even when data is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| etu_len | input | ETU_W | Clock cycles per etu (at least 3) |
| tx_en | input | 1 | Allows characters to start |
| ie_tx | input | 1 | Enable for the transfer request |
| ie_err | input | 1 | Enable for the error interrupt |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| wr_ctrl | input | 1 | Write comes from the transfer controller |
| ctrl_keep | input | 1 | Controller's keep-flags control |
| ctrl_left | input | CNT_W | Controller's remaining-transfer count |
| clr_empty | input | 1 | Software clear of the data-empty flag |
| clr_end | input | 1 | Software clear of the transmit-end flag |
| clr_err | input | 1 | Software clear of the error flag |
| line_in | input | 1 | Sampled level of the card line |
| line_out | output | 1 | Line drive: 0 pulls low, 1 releases |
| flag_empty | output | 1 | Holding register may be refilled |
| flag_end | output | 1 | Last character finished without error |
| flag_err | output | 1 | Sticky error-report flag |
| tx_req | output | 1 | Transfer request / transmit interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The embedded assertions check the following on every cycle:
- while a character is in flight, neither `flag_end` nor `tx_req` is high;
- `flag_err` falls only after `clr_err`;
- `flag_end` never rises without `flag_empty`;
- a resend reloads the holding byte;
- the etu counter stays in range.

Bit order, parity, the exact sampling cycle, the 12-etu and 14-etu spacing, and the four cases of the controller flag-clear rule can only be shown by the bench. It runs a cycle-accurate reference against clean sends, single and repeated error reports, disabled transmit, and every keep/remaining-count combination.

// File: rtl/cardtx_pkg.sv
// Package: shared constants of the smart-card transmitter.
// Assumes one character = start + 8 data + parity, then a guard region.
package cardtx_pkg;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned FRAME_BITS = DATA_W + 2;       // start, data, parity
    localparam int unsigned IDX_W      = 4;
    localparam logic [IDX_W-1:0] IDX_SAMPLE   = 4'(FRAME_BITS);      // etu where error is sampled
    localparam logic [IDX_W-1:0] IDX_DONE     = 4'(FRAME_BITS + 1);  // last etu of a clean character
    localparam logic [IDX_W-1:0] IDX_RESTART  = 4'(FRAME_BITS + 3);  // last etu before a resend

    typedef struct packed {
        logic start;   // character begins at this edge
        logic err;     // error report seen at this edge
        logic done;    // clean character finishes at this edge
    } frame_evt_t;
endpackage

// File: rtl/cardtx_etu.sv
// Module: etu timer. Counts clock cycles inside one etu while a character
// is in flight and flags the last cycle and the mid cycle of each etu.
// Assumes etu_len >= 3 and that etu_len is held stable during a character.
module cardtx_etu #(
    parameter int unsigned ETU_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ETU_W-1:0] etu_len,
    output logic             tick,
    output logic             mid
);
    logic [ETU_W-1:0] cyc;

    assign tick = run && (cyc == etu_len - 1'b1);
    assign mid  = run && (cyc == (etu_len >> 1));

    // Purpose: advance the cycle count, wrapping at each etu boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= '0;
        else if (!run || tick) cyc <= '0;
        else                 cyc <= cyc + 1'b1;
    end

    assert_cyc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (etu_len >= 3) |-> (cyc < etu_len));
endmodule

// File: rtl/cardtx_frame.sv
// Module: character sequencer. Shapes start/data/parity on the line,
// releases it in the guard region, samples the error report and
// restarts the same byte from the holding register after an error.
// Assumes hold_data is the holding register and go reflects pending data.
module cardtx_frame
    import cardtx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              tick,
    input  logic              mid,
    input  logic              line_in,
    output logic              busy,
    output logic              line_out,
    output frame_evt_t        evt
);
    logic [IDX_W-1:0]      idx;
    logic [DATA_W-1:0]     shreg;
    logic                  err_seen;
    logic [FRAME_BITS-1:0] frame_bits;
    logic                  restart;

    assign frame_bits = {^shreg, shreg, 1'b0};
    assign line_out   = (busy && idx < IDX_SAMPLE) ? frame_bits[idx] : 1'b1;

    assign evt.start = !busy && go;
    assign evt.err   = busy && (idx == IDX_SAMPLE) && mid && !line_in;
    assign evt.done  = busy && tick && (idx == IDX_DONE) && !err_seen;
    assign restart   = busy && tick && (idx == IDX_RESTART);

    // Purpose: step through the etu slots of a character and handle resends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            idx      <= '0;
            shreg    <= '0;
            err_seen <= 1'b0;
        end else if (evt.start) begin
            busy     <= 1'b1;
            idx      <= '0;
            shreg    <= hold_data;
            err_seen <= 1'b0;
        end else if (busy) begin
            if (evt.err) err_seen <= 1'b1;
            if (evt.done) begin
                busy <= 1'b0;
                idx  <= '0;
            end else if (restart) begin
                idx      <= '0;
                shreg    <= hold_data;
                err_seen <= 1'b0;
            end else if (tick) begin
                idx <= idx + 1'b1;
            end
        end
    end

    assert_resend_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && idx == '0 && $past(idx) == IDX_RESTART)
        |-> (shreg == $past(hold_data)));

    assert_err_in_sample_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_seen) |-> ($past(idx) == IDX_SAMPLE));
endmodule

// File: rtl/cardtx_flags.sv
// Module: holding register and status flags with the transfer-controller
// clear rule and the interrupt/request outputs.
// Assumes event pulses from the sequencer are single-cycle.
module cardtx_flags
    import cardtx_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_ctrl,
    input  logic              ctrl_keep,
    input  logic [CNT_W-1:0]  ctrl_left,
    input  logic              clr_empty,
    input  logic              clr_end,
    input  logic              clr_err,
    input  logic              ie_tx,
    input  logic              ie_err,
    input  frame_evt_t        evt,
    output logic [DATA_W-1:0] hold_data,
    output logic              flag_empty,
    output logic              flag_end,
    output logic              flag_err,
    output logic              tx_req,
    output logic              irq_err
);
    logic ctrl_clear;

    assign ctrl_clear = wr_en && wr_ctrl && !ctrl_keep && (ctrl_left != '0);
    assign tx_req     = flag_empty && ie_tx;
    assign irq_err    = flag_err && ie_err;

    // Purpose: capture each written byte into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_data <= '0;
        else if (wr_en) hold_data <= wr_data;
    end

    // Purpose: data-empty flag, set on clean completion, cleared by writes/software.
    always_ff @(posedge clk) begin
        if (!rst_n)                       flag_empty <= 1'b1;
        else if (evt.done)                flag_empty <= 1'b1;
        else if (ctrl_clear || clr_empty) flag_empty <= 1'b0;
    end

    // Purpose: transmit-end flag, set on clean completion, cleared at start or by clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  flag_end <= 1'b1;
        else if (evt.done)                           flag_end <= 1'b1;
        else if (ctrl_clear || clr_end || evt.start) flag_end <= 1'b0;
    end

    // Purpose: sticky error flag, cleared by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_err <= 1'b0;
        else if (evt.err) flag_err <= 1'b1;
        else if (clr_err) flag_err <= 1'b0;
    end

    assert_err_sw_clear_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_err) |-> $past(clr_err));

    assert_end_with_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_end) |-> flag_empty);
endmodule

// File: rtl/cardtx_retry.sv
// Module: top of the smart-card character transmitter with automatic resend.
// Ties the etu timer, character sequencer and flag block together.
// Assumes line_in is already synchronised to clk.
module cardtx_retry
    import cardtx_pkg::*;
#(
    parameter int unsigned ETU_W = 16,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ETU_W-1:0] etu_len,
    input  logic             tx_en,
    input  logic             ie_tx,
    input  logic             ie_err,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             wr_ctrl,
    input  logic             ctrl_keep,
    input  logic [CNT_W-1:0] ctrl_left,
    input  logic             clr_empty,
    input  logic             clr_end,
    input  logic             clr_err,
    input  logic             line_in,
    output logic             line_out,
    output logic             flag_empty,
    output logic             flag_end,
    output logic             flag_err,
    output logic             tx_req,
    output logic             irq_err
);
    logic              busy;
    logic              tick;
    logic              mid;
    logic              go;
    logic [DATA_W-1:0] hold_data;
    frame_evt_t        evt;

    assign go = tx_en && !flag_empty;

    cardtx_etu #(.ETU_W(ETU_W)) u_etu (
        .clk(clk), .rst_n(rst_n), .run(busy), .etu_len(etu_len),
        .tick(tick), .mid(mid)
    );

    cardtx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .go(go), .hold_data(hold_data),
        .tick(tick), .mid(mid), .line_in(line_in),
        .busy(busy), .line_out(line_out), .evt(evt)
    );

    cardtx_flags #(.CNT_W(CNT_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ctrl(wr_ctrl), .ctrl_keep(ctrl_keep), .ctrl_left(ctrl_left),
        .clr_empty(clr_empty), .clr_end(clr_end), .clr_err(clr_err),
        .ie_tx(ie_tx), .ie_err(ie_err), .evt(evt),
        .hold_data(hold_data), .flag_empty(flag_empty), .flag_end(flag_end),
        .flag_err(flag_err), .tx_req(tx_req), .irq_err(irq_err)
    );

    assert_quiet_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!flag_end && !tx_req));
endmodule

// File: tb/tb_cardtx_retry.sv
module tb_cardtx_retry;
    localparam int E = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, ie_tx = 1'b1, ie_err = 1'b1;
    logic       wr_en = 1'b0, wr_ctrl = 1'b0, ctrl_keep = 1'b0;
    logic [7:0] wr_data = 8'h00, ctrl_left = 8'h00;
    logic       clr_empty = 1'b0, clr_end = 1'b0, clr_err = 1'b0;
    logic       line_out, flag_empty, flag_end, flag_err, tx_req, irq_err;
    logic       inj_r = 1'b0;
    logic       line_in;

    always #4 clk = ~clk;   // 125 MHz

    assign line_in = line_out & ~inj_r;

    cardtx_retry dut (
        .clk(clk), .rst_n(rst_n), .etu_len(16'(E)), .tx_en(tx_en),
        .ie_tx(ie_tx), .ie_err(ie_err), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ctrl(wr_ctrl), .ctrl_keep(ctrl_keep), .ctrl_left(ctrl_left),
        .clr_empty(clr_empty), .clr_end(clr_end), .clr_err(clr_err),
        .line_in(line_in), .line_out(line_out), .flag_empty(flag_empty),
        .flag_end(flag_end), .flag_err(flag_err), .tx_req(tx_req), .irq_err(irq_err)
    );

    // reference model state
    int   total = 0, bad = 0, cycles = 0;
    int   m_t = 0, inj_left = 0, retries = 0, cleans = 0;
    bit   m_busy = 0, m_errseen = 0, m_empty = 1, m_end = 1, m_err = 0, cmp_on = 0;
    bit   m_in = 1;
    logic [7:0] m_hold = 0, m_data = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_line();
        int k;
        if (!m_busy) return 1'b1;
        k = m_t / E;
        if (k == 0) return 1'b0;
        if (k <= 8) return m_data[k-1];
        if (k == 9) return ^m_data;
        return 1'b1;
    endfunction

    // Model update: behaviour of the requirements, one clock at a time.
    always @(posedge clk) begin
        bit done, errs, start, again, cc;
        if (!rst_n) begin
            m_busy = 0; m_errseen = 0; m_empty = 1; m_end = 1; m_err = 0; m_hold = 0; m_t = 0;
        end else begin
            done = 0; errs = 0; start = 0; again = 0;
            cc = wr_en && wr_ctrl && !ctrl_keep && (ctrl_left != 0);
            if (m_busy) begin
                if (m_t == 10*E + E/2 && !m_in) errs = 1;
                if (m_t == 12*E - 1 && !m_errseen) done = 1;
                else if (m_t == 14*E - 1) again = 1;
            end else if (!m_empty && tx_en) start = 1;
            if (start) begin m_busy = 1; m_t = 0; m_data = m_hold; m_errseen = 0; end
            else if (m_busy) begin
                if (errs) m_errseen = 1;
                if (done) begin m_busy = 0; cleans++; end
                else if (again) begin
                    m_t = 0; m_data = m_hold; m_errseen = 0; retries++;
                    if (inj_left > 0) inj_left--;
                end else m_t++;
            end
            if (done) m_empty = 1; else if (cc || clr_empty) m_empty = 0;
            if (done) m_end = 1; else if (cc || clr_end || start) m_end = 0;
            if (errs) m_err = 1; else if (clr_err) m_err = 0;
            if (wr_en) m_hold = wr_data;
        end
    end

    // Compare on the falling edge; also prepare the card's error drive.
    always @(negedge clk) begin
        cycles++;
        m_in  = exp_line() & ~inj_r;
        if (cmp_on) begin
            chk(line_out === exp_line(), "R2 R3 R6 R11 line_out", int'(line_out), int'(exp_line()));
            chk(flag_empty === m_empty, "R7 R9 R10 flag_empty", int'(flag_empty), int'(m_empty));
            chk(flag_end === m_end, "R6 R7 R9 R10 flag_end", int'(flag_end), int'(m_end));
            chk(flag_err === m_err, "R4 R10 flag_err", int'(flag_err), int'(m_err));
            chk(tx_req === (m_empty & ie_tx), "R8 tx_req", int'(tx_req), int'(m_empty & ie_tx));
            chk(irq_err === (m_err & ie_err), "R5 irq_err", int'(irq_err), int'(m_err & ie_err));
        end
        inj_r = (inj_left > 0) && m_busy && (m_t >= 10*E + 1) && (m_t < 12*E - 2);
        m_in  = exp_line() & ~inj_r;
    end

    always @(posedge clk) if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic write_byte(input logic [7:0] d, input bit ctrl, input bit keep, input logic [7:0] left);
        @(negedge clk);
        wr_en = 1; wr_data = d; wr_ctrl = ctrl; ctrl_keep = keep; ctrl_left = left;
        @(negedge clk);
        wr_en = 0; wr_ctrl = 0; ctrl_keep = 0;
    endtask

    task automatic sw_clear(input bit e, input bit n, input bit r);
        @(negedge clk);
        clr_empty = e; clr_end = n; clr_err = r;
        @(negedge clk);
        clr_empty = 0; clr_end = 0; clr_err = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while ((m_busy || !m_empty) && n < 20000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int r0, c0;
        bit low_seen;
        repeat (3) @(negedge clk);
        chk(line_out === 1'b1, "R1 line_out reset", int'(line_out), 1);
        chk(flag_empty === 1'b1 && flag_end === 1'b1, "R1 empty/end reset", int'({flag_empty, flag_end}), 3);
        chk(flag_err === 1'b0, "R1 flag_err reset", int'(flag_err), 0);
        rst_n = 1; cmp_on = 1; tx_en = 1;

        // clean send by software
        c0 = cleans;
        write_byte(8'hA5, 0, 0, 0);
        chk(flag_empty === 1'b1, "R9 software write keeps empty", int'(flag_empty), 1);
        sw_clear(1, 1, 0);
        wait_idle();
        chk(cleans == c0 + 1, "R7 one clean character", cleans - c0, 1);

        // controller write that clears flags, two bytes
        write_byte(8'h3C, 1, 0, 8'd3);
        wait_idle();
        write_byte(8'hFF, 1, 0, 8'd1);
        wait_idle();

        // controller keep-flags: nothing starts
        write_byte(8'h81, 1, 1, 8'd5);
        repeat (4*E) @(negedge clk);
        chk(flag_empty === 1'b1 && flag_end === 1'b1, "R9 keep=1 flags stay", int'({flag_empty, flag_end}), 3);
        sw_clear(1, 1, 0);
        wait_idle();

        // controller remaining count zero: flags stay
        write_byte(8'h42, 1, 0, 8'd0);
        repeat (4*E) @(negedge clk);
        chk(flag_empty === 1'b1, "R9 left=0 flags stay", int'(flag_empty), 1);
        sw_clear(1, 0, 0);
        wait_idle();

        // single error then resend
        r0 = retries; c0 = cleans; inj_left = 1;
        write_byte(8'h5A, 1, 0, 8'd2);
        wait_idle();
        chk(retries == r0 + 1, "R6 one resend", retries - r0, 1);
        chk(flag_err === 1'b1, "R4 error flag latched", int'(flag_err), 1);
        chk(irq_err === 1'b1, "R5 error interrupt", int'(irq_err), 1);
        ie_err = 0;
        @(negedge clk);
        chk(irq_err === 1'b0, "R5 masked error interrupt", int'(irq_err), 0);
        sw_clear(0, 0, 1);
        ie_err = 1;

        // back-to-back errors, tx_req masked meanwhile
        r0 = retries; inj_left = 2; ie_tx = 0;
        write_byte(8'hC3, 1, 0, 8'd4);
        wait_idle();
        chk(retries == r0 + 2, "R6 two resends", retries - r0, 2);
        ie_tx = 1;
        sw_clear(0, 0, 1);

        // transmit disabled: pending byte does not start
        tx_en = 0;
        write_byte(8'h99, 1, 0, 8'd1);
        low_seen = 0;
        repeat (20*E) begin @(negedge clk); if (line_out !== 1'b1) low_seen = 1; end
        chk(!low_seen, "R11 no start while disabled", int'(low_seen), 0);
        chk(flag_empty === 1'b0, "R11 data still pending", int'(flag_empty), 0);
        tx_en = 1;
        wait_idle();

        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule